// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives configuration words over a write-only, three-wire serial link (data, shift clock and an active-low enable) and keeps them in a small set of control registers. A frame carries 14 data bits followed by a 4-bit register address, most significant bit first. When the enable returns high, the address at the tail of the frame selects which register takes the 14 data bits. The contents of each register are then presented as parallel control fields: two synthesizer divider ratios, amplifier gain and low-noise-amplifier enable, signed I and Q offset trims, and a word of band, oscillator and power-mode controls.

The three link pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected in the system clock domain, so the shift clock must stay in each level for at least three system clock periods. There is no stream data path: every pin is a plain level signal and nothing applies back-pressure. A sender can write at any time, and no length check is made on a frame.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every control field output is zero and `cfg_commit` is low.
- R2: Shift clock rising edges that occur while `ser_en_n` is high do not alter the shift register. After such edges, an enable pulse with no clocks writes the frame that was held before.
- R3: Bits enter MSB first. Of the last 18 bits, the first 14 are data (data bit 13 first) and the last 4 are the address (address bit 3 first).
- R4: Only the last 18 bits clocked in while enabled are kept. Any earlier bits in the same burst are discarded.
- R5: A rising edge of `ser_en_n` commits the frame whatever level `ser_clk` has at that moment. `cfg_commit` pulses high for exactly one system clock per commit.
- R6: Address 4'b0110 loads `if_div` from data bits 7..0. Data bits 13..8 are ignored.
- R7: Address 4'b0100 loads `rf_div` from data bits 13..0.
- R8: Address 4'b0011 loads `lna_on` from data bit 7 and `agc_code` from data bits 5..0.
- R9: Address 4'b0010 loads the following fields: `q_trim` from data bits 11..7, `q_pos` from bit 6, `i_trim` from bits 5..1 and `i_pos` from bit 0. A sign bit of 1 means a positive step.
- R10: Address 4'b0001 loads the following fields: `band_hi` from data bit 8, `ifvco_on` from bit 7, `rf_sect_on` from bit 4, `sw_syn` from bit 2, `sw_rx` from bit 1 and `sw_tx` from bit 0. Bits 6 and 5 reach no output.
- R11: Address 4'b0000 (reserved for test) and every address not listed above change no output field.
- R12: A new field value appears on the third rising system clock edge after the `ser_en_n` pin goes high. It does not appear earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_en_n | input | 1 | Active-low frame enable pin |
| cfg_commit | output | 1 | One-cycle pulse when a frame is committed |
| if_div | output | 8 | IF synthesizer divider ratio |
| rf_div | output | 14 | RF synthesizer divider ratio |
| lna_on | output | 1 | Low-noise amplifier enable |
| agc_code | output | 6 | Amplifier gain code |
| q_trim | output | 5 | Q channel offset magnitude |
| q_pos | output | 1 | Q offset sign, 1 = positive step |
| i_trim | output | 5 | I channel offset magnitude |
| i_pos | output | 1 | I offset sign, 1 = positive step |
| band_hi | output | 1 | Band select for divider programming |
| ifvco_on | output | 1 | 1 = internal IF oscillator, 0 = external LO buffer |
| rf_sect_on | output | 1 | RF receiver section enable in receive mode |
| sw_syn | output | 1 | Software synthesizer mode request |
| sw_rx | output | 1 | Software receive mode request |
| sw_tx | output | 1 | Software transmit mode request |

## Verification
A field changes two synchronizer edges plus one register edge after the enable pin rises, which makes three system clock edges in all. The bench drives each pin on a falling clock edge and samples on falling edges. After every enable rise it counts commit pulses over eight cycles and compares the fields only after that. One directed test samples `if_div` right after the second and the third rising edge to pin down the exact cycle. Each shift clock level is held for four system clocks, so every serial edge is seen once after synchronization.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int CFG_DATA_W = 14;
  localparam int CFG_ADDR_W = 4;

  localparam logic [CFG_ADDR_W-1:0] ADR_TEST  = 4'b0000;
  localparam logic [CFG_ADDR_W-1:0] ADR_MODE  = 4'b0001;
  localparam logic [CFG_ADDR_W-1:0] ADR_TRIM  = 4'b0010;
  localparam logic [CFG_ADDR_W-1:0] ADR_GAIN  = 4'b0011;
  localparam logic [CFG_ADDR_W-1:0] ADR_RFDIV = 4'b0100;
  localparam logic [CFG_ADDR_W-1:0] ADR_IFDIV = 4'b0110;

  typedef struct packed {
    logic band_hi;
    logic ifvco_on;
    logic rf_sect_on;
    logic syn;
    logic rx;
    logic tx;
  } mode_t;

  typedef struct packed {
    logic [4:0] q_mag;
    logic       q_pos;
    logic [4:0] i_mag;
    logic       i_pos;
  } trim_t;
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= async_in;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/serial_cfg_shifter.sv
module serial_cfg_shifter #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_clk,
  input  logic               s_en_n,
  input  logic               s_dat,
  output logic [FRAME_W-1:0] frame_q,
  output logic               en_rise
);
  logic clk_prev, en_prev, shift_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      en_prev  <= 1'b1;
    end else begin
      clk_prev <= s_clk;
      en_prev  <= s_en_n;
    end
  end

  assign shift_ev = s_clk && !clk_prev && !s_en_n;
  assign en_rise  = s_en_n && !en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else if (shift_ev) frame_q <= {frame_q[FRAME_W-2:0], s_dat};
  end

  // R2: nothing shifts while enable is inactive
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_en_n |=> $stable(frame_q));
  // R3: a new bit enters at the tail of the frame
  a_r3_tail_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> frame_q[0] == $past(s_dat));
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import serial_cfg_pkg::*;
#(
  parameter int DATA_W = CFG_DATA_W,
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int IFDIV_W = 8,
  parameter int AGC_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [DATA_W+ADDR_W-1:0]  frame,
  output logic                      commit_q,
  output logic [IFDIV_W-1:0]        if_div,
  output logic [DATA_W-1:0]         rf_div,
  output logic                      lna_on,
  output logic [AGC_W-1:0]          agc_code,
  output trim_t                     trim,
  output mode_t                     mode
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  assign addr = frame[ADDR_W-1:0];
  assign data = frame[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      if_div   <= '0;
      rf_div   <= '0;
      lna_on   <= 1'b0;
      agc_code <= '0;
      trim     <= '0;
      mode     <= '0;
    end else begin
      commit_q <= commit;
      if (commit) begin
        unique case (addr)
          ADR_IFDIV: if_div <= data[IFDIV_W-1:0];
          ADR_RFDIV: rf_div <= data;
          ADR_GAIN: begin
            lna_on   <= data[7];
            agc_code <= data[AGC_W-1:0];
          end
          ADR_TRIM: trim <= trim_t'(data[11:0]);
          ADR_MODE: mode <= '{band_hi: data[8], ifvco_on: data[7],
                              rf_sect_on: data[4], syn: data[2],
                              rx: data[1], tx: data[0]};
          default: ;
        endcase
      end
    end
  end

  logic [IFDIV_W+DATA_W+AGC_W+1+$bits(trim_t)+$bits(mode_t)-1:0] all_fields;
  assign all_fields = {if_div, rf_div, lna_on, agc_code, trim, mode};

  // R5: commit strobe lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  // R11: reserved test address leaves every field untouched
  a_r11_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == ADR_TEST) |=> $stable(all_fields));
  // R12: fields move only on a commit
  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(all_fields));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int DATA_W = CFG_DATA_W,
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic        ser_en_n,
  output logic        cfg_commit,
  output logic [7:0]  if_div,
  output logic [13:0] rf_div,
  output logic        lna_on,
  output logic [5:0]  agc_code,
  output logic [4:0]  q_trim,
  output logic        q_pos,
  output logic [4:0]  i_trim,
  output logic        i_pos,
  output logic        band_hi,
  output logic        ifvco_on,
  output logic        rf_sect_on,
  output logic        sw_syn,
  output logic        sw_rx,
  output logic        sw_tx
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [2:0] pins_s;
  logic [FRAME_W-1:0] frame;
  logic en_rise;
  trim_t trim;
  mode_t mode;

  serial_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_en_n, ser_clk, ser_data}),
    .sync_out(pins_s)
  );

  serial_cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .s_clk(pins_s[1]), .s_en_n(pins_s[2]), .s_dat(pins_s[0]),
    .frame_q(frame), .en_rise(en_rise)
  );

  serial_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IFDIV_W(8), .AGC_W(6)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(en_rise), .frame(frame),
    .commit_q(cfg_commit),
    .if_div(if_div), .rf_div(rf_div),
    .lna_on(lna_on), .agc_code(agc_code),
    .trim(trim), .mode(mode)
  );

  assign q_trim     = trim.q_mag;
  assign q_pos      = trim.q_pos;
  assign i_trim     = trim.i_mag;
  assign i_pos      = trim.i_pos;
  assign band_hi    = mode.band_hi;
  assign ifvco_on   = mode.ifvco_on;
  assign rf_sect_on = mode.rf_sect_on;
  assign sw_syn     = mode.syn;
  assign sw_rx      = mode.rx;
  assign sw_tx      = mode.tx;
endmodule

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 9;
  localparam logic [17:0] VEC [NVEC] = '{
    {14'h00A5, 4'b0110},  // R6
    {14'h3ABC, 4'b0100},  // R7
    {14'h00AD, 4'b0011},  // R8
    {14'h2C95, 4'b0010},  // R9
    {14'h01F7, 4'b0001},  // R10
    {14'h3F3C, 4'b0110},  // R6 upper bits ignored
    {14'h3FFF, 4'b0000},  // R11
    {14'h1234, 4'b0101},  // R11
    {14'h2AAA, 4'b1111}   // R11
  };

  logic clk = 0, rst_n = 0;
  logic ser_data = 0, ser_clk = 0, ser_en_n = 1;
  logic cfg_commit, lna_on, q_pos, i_pos, band_hi, ifvco_on, rf_sect_on, sw_syn, sw_rx, sw_tx;
  logic [7:0] if_div;
  logic [13:0] rf_div;
  logic [5:0] agc_code;
  logic [4:0] q_trim, i_trim;

  int n_checks = 0, n_fail = 0;
  int pulses;
  logic [7:0] snap2, snap3;
  logic [46:0] exp_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .cfg_commit(cfg_commit), .if_div(if_div), .rf_div(rf_div), .lna_on(lna_on),
    .agc_code(agc_code), .q_trim(q_trim), .q_pos(q_pos), .i_trim(i_trim), .i_pos(i_pos),
    .band_hi(band_hi), .ifvco_on(ifvco_on), .rf_sect_on(rf_sect_on),
    .sw_syn(sw_syn), .sw_rx(sw_rx), .sw_tx(sw_tx)
  );

  function automatic logic [46:0] observed();
    return {if_div, rf_div, lna_on, agc_code, q_trim, q_pos, i_trim, i_pos,
            band_hi, ifvco_on, rf_sect_on, sw_syn, sw_rx, sw_tx};
  endfunction

  // model from the requirements, same packing as observed()
  task automatic apply(input logic [17:0] f);
    logic [13:0] d = f[17:4];
    case (f[3:0])
      4'b0110: exp_v[46:39] = d[7:0];                         // R6
      4'b0100: exp_v[38:25] = d;                              // R7
      4'b0011: exp_v[24:18] = {d[7], d[5:0]};                 // R8
      4'b0010: exp_v[17:6]  = d[11:0];                        // R9
      4'b0001: exp_v[5:0]   = {d[8], d[7], d[4], d[2:0]};     // R10
      default: ;                                              // R11
    endcase
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; ser_clk = 0; wait_n(4);
    ser_clk = 1; wait_n(4);
  endtask

  // send n bits MSB first, then raise enable; counts commit pulses
  task automatic send(input logic [31:0] v, input int n, input bit end_high);
    ser_en_n = 0; wait_n(4);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    if (!end_high) begin ser_clk = 0; wait_n(4); end
    ser_en_n = 1;
    pulses = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (cfg_commit) pulses++;
      if (k == 2) snap2 = if_div;
      if (k == 3) snap3 = if_div;
    end
    ser_clk = 0; wait_n(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    exp_v = '0;
    wait_n(3);
    // R1: reset state
    check("R1 fields", {17'd0, observed()}, 64'd0);
    check("R1 commit", {63'd0, cfg_commit}, 64'd0);
    rst_n = 1;
    wait_n(3);

    // table walk: R3 framing, R6-R11 field decode
    for (int v = 0; v < NVEC; v++) begin
      send({14'd0, VEC[v]}, 18, 1'b0);
      apply(VEC[v]);
      check("R5 one pulse", pulses, 1);
      check($sformatf("R3 decode addr %b", VEC[v][3:0]), {17'd0, observed()}, {17'd0, exp_v});
    end

    // R4: leading extra bits dropped
    send({10'h3FF, 4'hF, 14'h0155, 4'b0110}, 22, 1'b0);
    apply({14'h0155, 4'b0110});
    check("R4 leading bits", {17'd0, observed()}, {17'd0, exp_v});

    // R5: commit while shift clock held high
    send({14'd0, 14'h1111, 4'b0100}, 18, 1'b1);
    apply({14'h1111, 4'b0100});
    check("R5 clock high commit", {17'd0, observed()}, {17'd0, exp_v});
    check("R5 pulse count", pulses, 1);

    // R2: clock edges while enable high are ignored
    ser_en_n = 1;
    for (int i = 0; i < 18; i++) shift_bit(i[0]);
    ser_clk = 0; wait_n(4);
    send(32'd0, 0, 1'b0);
    check("R2 ignored clocks", {17'd0, observed()}, {17'd0, exp_v});
    check("R2 pulse count", pulses, 1);

    // R12: exact update cycle
    send({14'd0, 14'h0077, 4'b0110}, 18, 1'b0);
    apply({14'h0077, 4'b0110});
    check("R12 not early", {56'd0, snap2}, {56'd0, 8'h55});
    check("R12 on time", {56'd0, snap3}, {56'd0, 8'h77});

    // R10: reserved mode bits 6,5 alone reach nothing
    send({14'd0, 14'h0060, 4'b0001}, 18, 1'b0);
    apply({14'h0060, 4'b0001});
    check("R10 reserved bits", {58'd0, observed()[5:0]}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule